// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host reach an external asynchronous static RAM of 65,536 sixteen-bit words. The host offers one transfer at a time with a single-cycle request while `ready` is high. The request carries a write flag, a word address, write data and a two-bit lane mask. Reads return the selected lanes of the addressed word together with a one-cycle `rdValid` pulse.

On the memory side the controller drives active-low chip, output, write and per-lane byte enables, plus the address. The shared data bus is split into an output value, an output-enable and an input value, so that the pad-level tristate sits outside the block. Phase lengths are not fixed. Each comes from a time limit in picoseconds divided by the clock period and rounded up to whole cycles, with a floor of one cycle. Writes are strobed by the write enable. The controller never switches its data drivers on while the memory could still be driving the bus.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `memCeN`, `memOeN`, `memWeN`, `memLbN` and `memUbN` are 1, `memDqOe` is 0, `ready` is 1 and `rdValid` is 0.
- R2: Each phase length is ceil(limit / CLK_PS) cycles, and at least 1. Read access uses ACC_PS, the write-enable pulse uses WP_PS and bus release uses REL_PS. With CLK_PS=20000, ACC_PS=50000, WP_PS=30000 and REL_PS=25000, `memOeN` is low for 3 cycles per read and `memWeN` is low for 2 cycles per write.
- R3: A read holds `memCeN`=0, `memOeN`=0 and `memWeN`=1 for the access phase. It captures `memDqIn` on the last access cycle and raises `rdValid` for exactly one cycle, with `rdData` valid in that cycle.
- R4: Mask bit 0 selects data bits 7:0 through `memLbN`, and mask bit 1 selects bits 15:8 through `memUbN`. A deselected lane is not written. A deselected lane reads back as zero. With a mask of 0, nothing is written.
- R5: A write spends one cycle with chip enable low and write enable high, then the write-enable pulse, then one more cycle with write enable high. Address, data and lane enables do not change while `memWeN` is low.
- R6: `memDqOe` is never 1 while `memOeN` is 0. After `memOeN` rises, at least REL cycles pass before `memDqOe` turns on.
- R7: `ready` is 0 from the cycle after an accepted request until the transfer ends. A read keeps it low for ACC+REL cycles and a write for WP+2 cycles. A request raised while `ready` is 0 is ignored.
- R8: `memAddr` equals the accepted request address during every cycle in which `memCeN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Single-cycle transfer request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select (bit 0 low byte, bit 1 high byte) |
| ready | output | 1 | High when a request may be accepted |
| rdData | output | 16 | Read data, deselected lanes zero |
| rdValid | output | 1 | One-cycle read-data strobe |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLbN | output | 1 | Low-byte enable, active low |
| memUbN | output | 1 | High-byte enable, active low |
| memDqOut | output | 16 | Data driven toward memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data seen on the memory bus |

## Verification
The hardest case to reach is a write that directly follows a read. Here the driver turn-on has to wait out the memory's release time, and this hazard only shows up when a read and a write sit back to back. The stimulus table places writes straight after reads and repeats back-to-back writes. The bench memory model drives the bus whenever its read conditions hold, and a monitor counts the cycles with the output enable high before each driver turn-on. The model also returns garbage until the access time has elapsed, so a controller that samples early is caught.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RACC, S_RREL, S_WSET, S_WPUL, S_WHLD
  } state_t;

  typedef struct packed {
    logic load;
    logic sample;
    logic chip;
    logic outEn;
    logic wrEn;
    logic drive;
  } strobe_t;

  function automatic int cyclesFor(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    if (c < 1) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ACC_CYC = 1,
  parameter int WP_CYC  = 1,
  parameter int REL_CYC = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    reqWrite,
  output logic    ready,
  output strobe_t stb
);
  localparam int MAX_A = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int MAX_C = (MAX_A > REL_CYC) ? MAX_A : REL_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  state_t state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic lastCyc;

  always_comb begin
    case (state)
      S_RACC:  lastCyc = (cnt == CNT_W'(ACC_CYC - 1));
      S_RREL:  lastCyc = (cnt == CNT_W'(REL_CYC - 1));
      S_WPUL:  lastCyc = (cnt == CNT_W'(WP_CYC - 1));
      default: lastCyc = 1'b1;
    endcase
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE: if (req) stateNext = reqWrite ? S_WSET : S_RACC;
      S_RACC: if (lastCyc) stateNext = S_RREL;
      S_RREL: if (lastCyc) stateNext = S_IDLE;
      S_WSET: stateNext = S_WPUL;
      S_WPUL: if (lastCyc) stateNext = S_WHLD;
      S_WHLD: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stb.load   = (state == S_IDLE) && req;
    stb.sample = (state == S_RACC) && lastCyc;
    stb.chip   = (state == S_RACC) || (state == S_WSET) ||
                 (state == S_WPUL) || (state == S_WHLD);
    stb.outEn  = (state == S_RACC);
    stb.wrEn   = (state == S_WPUL);
    stb.drive  = (state == S_WSET) || (state == S_WPUL) || (state == S_WHLD);
  end

  assign ready = (state == S_IDLE);
endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] gated;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (stb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign gated[i*8 +: 8] = maskQ[i] ? memDqIn[i*8 +: 8] : 8'h00;
    assign laneN[i]        = ~(stb.chip & maskQ[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.sample;
      if (stb.sample) rdData <= gated;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memDqOe  = stb.drive;
  assign memCeN   = ~stb.chip;
  assign memOeN   = ~stb.outEn;
  assign memWeN   = ~stb.wrEn;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PS = 20000,
  parameter int ACC_PS = 10000,
  parameter int WP_PS  = 7000,
  parameter int REL_PS = 4000,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqMask,
  output logic              ready,
  output logic [15:0]       rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [15:0]       memDqOut,
  output logic              memDqOe,
  input  logic [15:0]       memDqIn
);
  localparam int ACC_CYC = cyclesFor(ACC_PS, CLK_PS);
  localparam int WP_CYC  = cyclesFor(WP_PS, CLK_PS);
  localparam int REL_CYC = cyclesFor(REL_PS, CLK_PS);

  strobe_t stb;
  logic [LANES-1:0] laneN;

  sram_ctl_fsm #(.ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .REL_CYC(REL_CYC)) uFsm (
    .clk(clk), .rst(rst), .req(req), .reqWrite(reqWrite),
    .ready(ready), .stb(stb)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rst(rst), .stb(stb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .memDqIn(memDqIn), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .laneN(laneN), .rdData(rdData), .rdValid(rdValid)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int REL_CYC = 1,
  parameter int ADDR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rdValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memLbN,
  input logic              memUbN,
  input logic              memDqOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [15:0]       memDqOut
);
  int relCnt;

  always_ff @(posedge clk) begin
    if (rst)          relCnt <= REL_CYC;
    else if (!memOeN) relCnt <= 0;
    else if (relCnt < REL_CYC) relCnt <= relCnt + 1;
  end

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> !memDqOe);

  // R6
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(memDqOe) |-> relCnt >= REL_CYC);

  // R5
  wr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && $past(!memWeN)) |->
      ($stable(memAddr) && $stable(memDqOut) && $stable(memLbN) && $stable(memUbN)));

  // R5
  wr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> ($past(!memCeN) && $past(memDqOe)));

  // R5
  wr_recover_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (!memCeN && memDqOe));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  // R7
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    !memCeN |-> !ready);
endmodule

bind sram_ctl sram_ctl_chk #(.REL_CYC(REL_CYC), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;
  localparam int CLKP  = 20000;
  localparam int ACCP  = 50000;
  localparam int WPP   = 30000;
  localparam int RELP  = 25000;
  localparam int ACCN  = (ACCP + CLKP - 1) / CLKP;
  localparam int WPN   = (WPP + CLKP - 1) / CLKP;
  localparam int RELN  = (RELP + CLKP - 1) / CLKP;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0010, 16'hA5C3, 2'b11, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA5C3},
    '{1'b1, 16'h0010, 16'h1234, 2'b01, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hA534},
    '{1'b1, 16'h0010, 16'hFF00, 2'b10, 16'h0000},
    '{1'b0, 16'h0010, 16'h0000, 2'b11, 16'hFF34},
    '{1'b0, 16'h0010, 16'h0000, 2'b01, 16'h0034},
    '{1'b0, 16'h0010, 16'h0000, 2'b10, 16'hFF00},
    '{1'b1, 16'h0022, 16'hBEEF, 2'b00, 16'h0000},
    '{1'b0, 16'h0022, 16'h0000, 2'b11, 16'h0000},
    '{1'b1, 16'h0022, 16'hBEEF, 2'b11, 16'h0000},
    '{1'b1, 16'h0023, 16'h0F0F, 2'b11, 16'h0000},
    '{1'b0, 16'h0022, 16'h0000, 2'b11, 16'hBEEF},
    '{1'b0, 16'h0023, 16'h0000, 2'b11, 16'h0F0F},
    '{1'b1, 16'hC055, 16'h55AA, 2'b11, 16'h0000},
    '{1'b0, 16'hC055, 16'h0000, 2'b11, 16'h55AA},
    '{1'b0, 16'h00FF, 16'h0000, 2'b11, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic ready, rdValid, memCeN, memOeN, memWeN, memLbN, memUbN, memDqOe;
  logic [15:0] rdData, memAddr, memDqOut;
  logic [15:0] memDqIn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  sram_ctl #(.CLK_PS(CLKP), .ACC_PS(ACCP), .WP_PS(WPP), .REL_PS(RELP)) u0 (
    .clk(clk), .rst(rst), .req(req), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .ready(ready), .rdData(rdData),
    .rdValid(rdValid), .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memLbN(memLbN), .memUbN(memUbN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // memory model: 256 words indexed by the low address byte
  logic [15:0] mem [256];
  int oeLowCnt = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(posedge memWeN) begin
    if (memCeN === 1'b0) begin
      if (!memLbN) mem[memAddr[7:0]][7:0]  <= memDqOut[7:0];
      if (!memUbN) mem[memAddr[7:0]][15:8] <= memDqOut[15:8];
    end
  end

  always @(posedge clk) begin
    if (memOeN !== 1'b0) oeLowCnt <= 0;
    else                 oeLowCnt <= oeLowCnt + 1;
  end

  always_comb begin
    memDqIn = 16'hzzzz;
    if (memCeN === 1'b0 && memOeN === 1'b0 && memWeN === 1'b1) begin
      if (!memLbN) memDqIn[7:0]  = (oeLowCnt >= ACCN - 1) ? mem[memAddr[7:0]][7:0]  : 8'hAD;
      if (!memUbN) memDqIn[15:8] = (oeLowCnt >= ACCN - 1) ? mem[memAddr[7:0]][15:8] : 8'hDE;
    end
  end

  // bus turnaround monitor
  int contErr = 0;
  int turnErr = 0;
  int oeHighCnt = 0;
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (memDqOe && !memOeN) contErr++;
      if (memDqOe && !prevOe && oeHighCnt < RELN) turnErr++;
    end
    prevOe = memDqOe;
    if (memOeN) oeHighCnt++;
    else        oeHighCnt = 0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic wr, input logic [15:0] addr, input logic [15:0] data,
                      input logic [1:0] mask, output logic [15:0] rd, output int busy,
                      output int oeLow, output int weLow, output int vcnt, output int addrBad,
                      output int stabBad);
    busy = 0; oeLow = 0; weLow = 0; vcnt = 0; addrBad = 0; stabBad = 0; rd = '0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data; reqMask = mask;
    @(negedge clk);
    req = 1'b0;
    while (!ready) begin
      busy++;
      if (!memOeN) oeLow++;
      if (!memCeN && memAddr != addr) addrBad++;
      if (!memWeN) begin
        weLow++;
        if (memDqOut != data || !memDqOe || memLbN != !mask[0] || memUbN != !mask[1])
          stabBad++;
      end
      if (rdValid) begin vcnt++; rd = rdData; end
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] rd;
    int busy, oeLow, weLow, vcnt, addrBad, stabBad;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(memCeN && memOeN && memWeN && memLbN && memUbN, "R1 controls in reset",
        {memCeN, memOeN, memWeN, memLbN, memUbN}, 5'h1F);
    chk(!memDqOe && ready && !rdValid, "R1 drive/ready/valid in reset",
        {memDqOe, ready, rdValid}, 3'b010);
    rst = 1'b0;
    @(negedge clk);
    chk(memCeN && memOeN && memWeN && !memDqOe && ready, "R1 after reset",
        {memCeN, memOeN, memWeN, memDqOe, ready}, 5'b11101);

    for (int v = 0; v < NV; v++) begin
      xact(VECS[v].wr, VECS[v].addr, VECS[v].data, VECS[v].mask,
           rd, busy, oeLow, weLow, vcnt, addrBad, stabBad);
      chk(addrBad == 0, "R8 address during access", addrBad, 0);
      if (VECS[v].wr) begin
        chk(weLow == WPN, "R2 write pulse length", weLow, WPN);
        chk(busy == WPN + 2, "R7 write busy length", busy, WPN + 2);
        chk(stabBad == 0, "R5 stable while write enable low", stabBad, 0);
        chk(oeLow == 0 && vcnt == 0, "R5 no output enable or valid in write", oeLow, 0);
      end else begin
        chk(oeLow == ACCN, "R2 access length", oeLow, ACCN);
        chk(busy == ACCN + RELN, "R7 read busy length", busy, ACCN + RELN);
        chk(vcnt == 1, "R3 single valid pulse", vcnt, 1);
        chk(rd == VECS[v].exp, "R3 R4 read data", rd, VECS[v].exp);
        chk(weLow == 0, "R3 write enable stays high in read", weLow, 0);
      end
    end

    // R7: a request while busy is ignored
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0040; reqWdata = 16'h7777; reqMask = 2'b11;
    @(negedge clk);
    reqWrite = 1'b0; reqAddr = 16'h0041; reqWdata = 16'h1111;
    @(negedge clk);
    req = 1'b0;
    while (!ready) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(ready && memCeN, "R7 no extra transfer after busy request", {ready, memCeN}, 2'b11);
      @(negedge clk);
    end
    xact(1'b0, 16'h0040, 16'h0, 2'b11, rd, busy, oeLow, weLow, vcnt, addrBad, stabBad);
    chk(rd == 16'h7777, "R7 accepted write landed", rd, 16'h7777);
    xact(1'b0, 16'h0041, 16'h0, 2'b11, rd, busy, oeLow, weLow, vcnt, addrBad, stabBad);
    chk(rd == 16'h0000, "R7 ignored request left word untouched", rd, 16'h0000);

    chk(contErr == 0, "R6 bus contention cycles", contErr, 0);
    chk(turnErr == 0, "R6 release gap before drive", turnErr, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule